// File: doc/BRIEF.md
# Return Address Unstacker

This block handles the memory side of a subroutine return or an interrupt return. A single strobe starts it. The block pops one, two or three 16-bit words from the stack through a read port. It then presents the restored 24-bit program counter and the advanced stack pointer. For an interrupt return it also presents the restored status word. Three inputs fix the number of words and their meaning: the return kind, the page-zero mode flag and the incoming stack pointer. The caller takes the page-zero flag from bit 0 of its system configuration register.

An interrupt return holds the status word at the stack pointer, with the return address above it. A plain return holds the return address directly at the stack pointer. The low address word always comes first. Outside page-zero mode a second word follows it. Only the low 8 bits of that second word become PC bits 23:16. In page-zero mode the second word is not read and the upper PC bits are zero.

The read port uses a valid/ready handshake. `rd_req` acts as valid and `rd_ready` as ready. The memory may hold `rd_ready` low for any number of cycles. While it does, `rd_req` and `rd_addr` do not change. A word transfers in the cycle where both signals are high, and `rd_data` must be valid in that cycle. The block has no back-pressure on its result side: `done` is a one-cycle pulse.

Top module: `ret_unstacker`

## Requirements
- R1: Plain return, page-zero off. Two words are read, at SP and then SP+2. PC = {second word bits 7:0, first word}. The new SP is SP+4.
- R2: Plain return, page-zero on. One word is read, at SP. PC = {8'h00, word}. The new SP is SP+2.
- R3: Interrupt return, page-zero off. Three words are read. The status word comes from SP, the low address from SP+2 and the high address from SP+4. The new SP is SP+6.
- R4: Interrupt return, page-zero on. Two words are read: the status word from SP and the low address from SP+2. PC bits 23:16 are zero and the new SP is SP+4.
- R5: Bits 15:8 of the high address word have no effect on the PC.
- R6: `psw_we` pulses together with `done` only for an interrupt return. After a plain return, `psw_out` keeps its previous value.
- R7: `done` is high for exactly one cycle. That cycle directly follows the cycle of the final read transfer. `pc_out`, `psw_out` and `sp_out` take their new values in that same cycle.
- R8: While `rd_req` is high and `rd_ready` is low, `rd_req` stays high and `rd_addr` stays stable on the next cycle. `rd_data` is used only on a transfer.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in progress finishes with its own inputs.
- R10: During reset and after it, `done`, `rd_req`, `psw_we` and `busy` are low and `pc_out`, `psw_out` and `sp_out` are zero.
- R11: Stack addresses and the new SP wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an unstack; sampled only when idle |
| ret_intr | input | 1 | 1 = interrupt return, 0 = plain return |
| sp_in | input | 16 | Stack pointer at start |
| page_zero | input | 1 | Page-zero mode (system configuration bit 0) |
| rd_req | output | 1 | Stack read request (valid) |
| rd_addr | output | 16 | Stack read byte address |
| rd_ready | input | 1 | Memory accepts request; data valid this cycle |
| rd_data | input | 16 | Stack read data |
| pc_out | output | 24 | Restored program counter |
| psw_out | output | 16 | Restored status word |
| psw_we | output | 1 | Status word write strobe |
| sp_out | output | 16 | Updated stack pointer |
| done | output | 1 | Result valid pulse |
| busy | output | 1 | Unstack in progress |

## Verification
Some rules are checked on every cycle:
- the request and address hold steady while ready is low;
- the status strobe appears only with `done`;
- `done` never lasts two cycles;
- the SP step at completion is always 2, 4 or 6 bytes;
- page-zero completions carry zero upper PC bits.

Other behaviour can only be shown by the bench's scenarios:
- that the right words land in the right PC fields;
- that the read order and count match each mode;
- that stack addresses wrap;
- that a second start during a run is ignored.

// File: rtl/ret_unstack_pkg.sv
package ret_unstack_pkg;
  typedef enum logic [1:0] {
    ROLE_PSW = 2'd0,
    ROLE_LO  = 2'd1,
    ROLE_HI  = 2'd2
  } word_role_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } seq_state_e;

  localparam int MAX_WORDS = 3;
  localparam int IDX_W     = 2;
endpackage

// File: rtl/ret_word_sched.sv
// Latches the request, counts stack words and maps each index to its role.
module ret_word_sched
  import ret_unstack_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [SP_W-1:0]  sp_in,
  input  logic             intr_in,
  input  logic             pz_in,
  output logic [SP_W-1:0]  rd_addr,
  output logic [SP_W-1:0]  sp_base,
  output logic [SP_W-1:0]  sp_next,
  output word_role_e       role,
  output logic             last,
  output logic             intr_q,
  output logic             pz_q
);
  localparam int STEP = WORD_W / 8;

  logic [SP_W-1:0]  base_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] total;
  logic [IDX_W-1:0] eff_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      intr_q <= 1'b0;
      pz_q   <= 1'b0;
    end else if (load) begin
      base_q <= sp_in;
      idx_q  <= '0;
      intr_q <= intr_in;
      pz_q   <= pz_in;
    end else if (advance) begin
      idx_q  <= last ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    total   = IDX_W'(1) + IDX_W'(intr_q) + IDX_W'(!pz_q);
    last    = (idx_q == total - 1'b1);
    eff_idx = idx_q - IDX_W'(intr_q);
    if (intr_q && idx_q == '0) role = ROLE_PSW;
    else if (eff_idx == '0)    role = ROLE_LO;
    else                       role = ROLE_HI;
    rd_addr = base_q + SP_W'(idx_q) * SP_W'(STEP);
    sp_next = base_q + SP_W'(total) * SP_W'(STEP);
    sp_base = base_q;
  end
endmodule

// File: rtl/ret_result_reg.sv
// Stages popped words and commits PC, status word and SP with done.
module ret_result_reg
  import ret_unstack_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int WORD_W = 16,
  parameter int PC_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              last,
  input  word_role_e        role,
  input  logic              intr_q,
  input  logic              pz_q,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [SP_W-1:0]   sp_next,
  output logic [PC_W-1:0]   pc_out,
  output logic [WORD_W-1:0] psw_out,
  output logic              psw_we,
  output logic [SP_W-1:0]   sp_out,
  output logic              done
);
  localparam int HI_W = PC_W - WORD_W;

  logic [WORD_W-1:0] lo_stage;
  logic [WORD_W-1:0] psw_stage;
  logic [WORD_W-1:0] lo_val;
  logic [WORD_W-1:0] psw_val;
  logic [HI_W-1:0]   hi_val;

  always_comb begin
    lo_val  = (role == ROLE_LO)  ? rd_data : lo_stage;
    psw_val = (role == ROLE_PSW) ? rd_data : psw_stage;
    hi_val  = (role == ROLE_HI && !pz_q) ? rd_data[HI_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage  <= '0;
      psw_stage <= '0;
      pc_out    <= '0;
      psw_out   <= '0;
      psw_we    <= 1'b0;
      sp_out    <= '0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      psw_we <= 1'b0;
      if (xfer) begin
        lo_stage  <= lo_val;
        psw_stage <= psw_val;
        if (last) begin
          done   <= 1'b1;
          pc_out <= {hi_val, lo_val};
          sp_out <= sp_next;
          if (intr_q) begin
            psw_out <= psw_val;
            psw_we  <= 1'b1;
          end
        end
      end
    end
  end

  assert_we_only_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |-> done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/ret_unstacker.sv
module ret_unstacker
  import ret_unstack_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int WORD_W = 16,
  parameter int PC_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ret_intr,
  input  logic [SP_W-1:0]   sp_in,
  input  logic              page_zero,
  output logic              rd_req,
  output logic [SP_W-1:0]   rd_addr,
  input  logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic [PC_W-1:0]   pc_out,
  output logic [WORD_W-1:0] psw_out,
  output logic              psw_we,
  output logic [SP_W-1:0]   sp_out,
  output logic              done,
  output logic              busy
);
  localparam int HI_W = PC_W - WORD_W;

  seq_state_e      state_q;
  logic            load;
  logic            xfer;
  logic            last;
  logic            intr_q;
  logic            pz_q;
  word_role_e      role;
  logic [SP_W-1:0] sp_next;
  logic [SP_W-1:0] sp_base;
  logic [SP_W-1:0] sp_delta;

  assign busy   = (state_q == ST_READ);
  assign rd_req = busy;
  assign load   = start && !busy;
  assign xfer   = rd_req && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (load) begin
      state_q <= ST_READ;
    end else if (xfer && last) begin
      state_q <= ST_IDLE;
    end
  end

  ret_word_sched #(.SP_W(SP_W), .WORD_W(WORD_W)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (xfer),
    .sp_in   (sp_in),
    .intr_in (ret_intr),
    .pz_in   (page_zero),
    .rd_addr (rd_addr),
    .sp_base (sp_base),
    .sp_next (sp_next),
    .role    (role),
    .last    (last),
    .intr_q  (intr_q),
    .pz_q    (pz_q)
  );

  ret_result_reg #(.SP_W(SP_W), .WORD_W(WORD_W), .PC_W(PC_W)) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer    (xfer),
    .last    (last),
    .role    (role),
    .intr_q  (intr_q),
    .pz_q    (pz_q),
    .rd_data (rd_data),
    .sp_next (sp_next),
    .pc_out  (pc_out),
    .psw_out (psw_out),
    .psw_we  (psw_we),
    .sp_out  (sp_out),
    .done    (done)
  );

  assign sp_delta = sp_out - sp_base;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  assert_sp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sp_delta == SP_W'(2) || sp_delta == SP_W'(4) || sp_delta == SP_W'(6)));

  assert_pz_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pz_q) |-> (pc_out[PC_W-1 -: HI_W] == '0));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(xfer && last)) |=> busy);
endmodule

// File: tb/tb_ret_unstacker.sv
module tb_ret_unstacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ret_intr = 1'b0;
  logic [15:0] sp_in = '0;
  logic        page_zero = 1'b0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_data = '0;
  logic [23:0] pc_out;
  logic [15:0] psw_out;
  logic        psw_we;
  logic [15:0] sp_out;
  logic        done;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  logic [15:0] psw_model = '0;

  always #4 clk = ~clk;

  ret_unstacker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ret_intr(ret_intr),
    .sp_in(sp_in), .page_zero(page_zero), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .pc_out(pc_out), .psw_out(psw_out),
    .psw_we(psw_we), .sp_out(sp_out), .done(done), .busy(busy)
  );

  typedef struct packed {
    logic        intr;
    logic        pz;
    logic [15:0] sp;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [1:0]  stall;
    logic [23:0] pc;
    logic [15:0] sp_new;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0100, 16'h1234, 16'h0056, 16'h0000, 2'd0, 24'h561234, 16'h0104}, // R1
    '{1'b0, 1'b1, 16'h0200, 16'hBEEF, 16'h0000, 16'h0000, 2'd1, 24'h00BEEF, 16'h0202}, // R2
    '{1'b1, 1'b0, 16'h0300, 16'h00A5, 16'h4000, 16'h0012, 2'd0, 24'h124000, 16'h0306}, // R3
    '{1'b1, 1'b1, 16'h0400, 16'h0081, 16'h2222, 16'h0000, 2'd2, 24'h002222, 16'h0404}, // R4
    '{1'b0, 1'b0, 16'h0500, 16'hFFFE, 16'hAB7F, 16'h0000, 2'd0, 24'h7FFFFE, 16'h0504}, // R5
    '{1'b1, 1'b0, 16'hFFFC, 16'h0003, 16'h1111, 16'h00C3, 2'd1, 24'hC31111, 16'h0002}, // R11
    '{1'b0, 1'b1, 16'hFFFE, 16'h0A0A, 16'h0000, 16'h0000, 2'd0, 24'h000A0A, 16'h0000}, // R11
    '{1'b0, 1'b0, 16'h1000, 16'h0002, 16'h0001, 16'h0000, 2'd3, 24'h010002, 16'h1004}  // R8
  };

  function automatic string req_of(input int id);
    case (id)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R11";
      6: return "R11";
      7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int id, input bit glitch);
    logic [15:0] w [3];
    int k = 0;
    int stall = 0;
    int cyc = 0;
    int nwords;
    bit last_hs = 0;
    bit hs;
    string rq;
    rq = req_of(id);
    w[0] = v.w0; w[1] = v.w1; w[2] = v.w2;
    nwords = 1 + int'(v.intr) + int'(!v.pz);
    @(negedge clk);
    start = 1'b1; ret_intr = v.intr; page_zero = v.pz; sp_in = v.sp; rd_ready = 1'b0;
    @(negedge clk);
    forever begin
      if (glitch && cyc == 0) begin
        // R9: second start while busy, different inputs
        start = 1'b1; ret_intr = ~v.intr; page_zero = ~v.pz; sp_in = 16'h7000;
      end else begin
        start = 1'b0;
      end
      if (done) break;
      if (last_hs) begin
        check(1'b0, "R7", "done after last transfer", 32'(done), 32'h1);
        break;
      end
      if (rd_req) begin
        check(rd_addr == 16'(v.sp + 16'(2 * k)), rq, "rd_addr", 32'(rd_addr), 32'(v.sp + 16'(2 * k)));
        if (stall >= int'(v.stall)) begin
          rd_ready = 1'b1; rd_data = w[k];
        end else begin
          rd_ready = 1'b0; rd_data = 16'hDEAD;
        end
      end else begin
        rd_ready = 1'b0;
      end
      hs = rd_req && rd_ready;
      @(negedge clk);
      if (hs) begin
        k++; stall = 0; last_hs = (k == nwords);
      end else begin
        stall++;
      end
      cyc++;
      if (cyc > 60) begin
        check(1'b0, rq, "no completion", 32'(cyc), 32'd0);
        break;
      end
    end
    start = 1'b0; rd_ready = 1'b0;
    if (done) begin
      check(k == nwords, rq, "word count", 32'(k), 32'(nwords));
      check(pc_out == v.pc, rq, "pc_out", 32'(pc_out), 32'(v.pc));
      check(sp_out == v.sp_new, rq, "sp_out", 32'(sp_out), 32'(v.sp_new));
      if (v.intr) psw_model = v.w0;
      check(psw_we == v.intr, "R6", "psw_we", 32'(psw_we), 32'(v.intr));
      check(psw_out == psw_model, "R6", "psw_out", 32'(psw_out), 32'(psw_model));
      @(negedge clk);
      check(!done && !psw_we, "R7", "done pulse width", 32'(done), 32'h0);
      check(!busy, "R7", "idle after done", 32'(busy), 32'h0);
    end
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      cnt++;
      if (cnt > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cnt);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: values held in reset
    check(!done && !rd_req && !psw_we && !busy, "R10", "control in reset",
          {28'h0, done, rd_req, psw_we, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_out == '0 && sp_out == '0 && psw_out == '0, "R10", "data after reset",
          32'(pc_out) | 32'(sp_out) | 32'(psw_out), 32'h0);
    check(!rd_req && !done, "R10", "idle after reset", {30'h0, rd_req, done}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i, 1'b0);

    // R9: restart attempt during an interrupt return with wait states
    run_vec(VECS[3], 8, 1'b1);
    // R9: restart attempt during a plain return
    run_vec(VECS[0], 8, 1'b1);
    // R6: plain return after interrupt return keeps status word
    run_vec(VECS[2], 2, 1'b0);
    run_vec(VECS[4], 4, 1'b0);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule